// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block moves a DRAM subsystem into and out of self-refresh for a power manager. The power manager uses a level request and an acknowledge. A two-bit sleep-type field selects what the request means, and only code 0 (self-refresh) is acted on. On entry the sequencer sends a one-cycle command to the memory controller. It raises the acknowledge once the controller reports that it is in self-refresh.

When the request drops, the sequencer runs the recovery steps in a fixed order. It sends a PHY resynchronisation strobe first. With DDR2 memory it then sets the DRAM DLL reset, issues a mode-register command, waits for the controller to report that command done, and clears the DLL reset. LPDDR1 memory skips these DDR2 steps. Next it resets the PHY DLL and holds a controller-access block for a fixed cycle count. It then forces a slave DLL update, waits a second cycle count, and strobes the update again. The acknowledge falls only after that second strobe. The request is a level, so a change that arrives during a sequence is acted on when the sequencer next reaches a resting state.

Top module: `sr_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sleep_ack, access_block and every command strobe are 0.
- R2: A request is taken only when sleep_type is 2'd0. With sleep_type set to 1, 2 or 3, a high sleep_req produces no sr_enter strobe and sleep_ack stays 0.
- R3: With sleep_ack at 0, sleep_req at 1 and sleep_type at 0, sr_enter pulses one cycle later. sleep_ack rises one cycle after the cycle in which sr_entered is sampled high.
- R4: When sleep_req is sampled 0 while sleep_ack is 1, phy_sync pulses one cycle later. It is the first exit strobe.
- R5: When mem_ddr2 is 1, the exit strobes follow phy_sync on consecutive cycles: dram_dll_set, then mrs_cmd. The sequencer then waits for mrs_done. dram_dll_clr pulses one cycle after mrs_done is sampled high.
- R6: When mem_ddr2 is 0, dram_dll_set, mrs_cmd and dram_dll_clr never pulse, and phy_dll_rst pulses one cycle after phy_sync.
- R7: phy_dll_rst pulses in the first cycle of a window in which access_block is high for exactly PHY_WAIT consecutive cycles.
- R8: slave_upd pulses in the cycle after the access_block window ends. It pulses a second time exactly SLAVE_WAIT cycles later.
- R9: sleep_ack stays 1 through the whole exit sequence. It falls in the cycle after the second slave_upd pulse.
- R10: A request change during a sequence does not disturb it. If sleep_req drops during entry, exit starts one cycle after sleep_ack rises. If sleep_req rises during exit, sr_enter pulses one cycle after sleep_ack falls.
- R11: Every command strobe lasts one cycle, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Power-manager sleep request level |
| sleep_type | input | 2 | Sleep type select, 0 = self-refresh |
| mem_ddr2 | input | 1 | 1 = DDR2, 0 = LPDDR1 |
| sr_entered | input | 1 | Controller reports that it is in self-refresh |
| mrs_done | input | 1 | Controller reports that the mode-register command is complete |
| sleep_ack | output | 1 | Acknowledge to the power manager |
| sr_enter | output | 1 | Strobe: command self-refresh entry |
| phy_sync | output | 1 | Strobe: PHY resynchronisation |
| dram_dll_set | output | 1 | Strobe: set DRAM DLL reset |
| mrs_cmd | output | 1 | Strobe: issue mode-register set |
| dram_dll_clr | output | 1 | Strobe: clear DRAM DLL reset |
| phy_dll_rst | output | 1 | Strobe: reset PHY DLL |
| slave_upd | output | 1 | Strobe: force slave DLL update |
| access_block | output | 1 | Controller access blocked during PHY DLL reset |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-hot, single-cycle shape of the strobes, and entry only under sleep type 0 with the request high. They also check that the mode-register strobe appears only for DDR2, that the update strobe directly follows the end of the access block, and that the acknowledge falls only right after an update strobe. The exact cycle offsets can only be shown by the bench scenarios, which sweep memory type and the controller's response latencies. These offsets are the PHY_WAIT and SLAVE_WAIT window lengths, the mrs_done-driven DDR2 path, and how a request change during a sequence is taken up.

// File: rtl/sr_sequencer.sv
module sr_sequencer #(
  parameter int PHY_WAIT   = 2048,
  parameter int SLAVE_WAIT = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] sleep_type,
  input  logic       mem_ddr2,
  input  logic       sr_entered,
  input  logic       mrs_done,
  output logic       sleep_ack,
  output logic       sr_enter,
  output logic       phy_sync,
  output logic       dram_dll_set,
  output logic       mrs_cmd,
  output logic       dram_dll_clr,
  output logic       phy_dll_rst,
  output logic       slave_upd,
  output logic       access_block
);

  localparam int MAXW = (PHY_WAIT > SLAVE_WAIT) ? PHY_WAIT : SLAVE_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] PHY_LAST   = CW'(PHY_WAIT - 1);
  localparam logic [CW-1:0] SLAVE_LAST = CW'(SLAVE_WAIT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ENTER, S_WENT, S_SR, S_SYNC, S_DSET, S_MRS, S_MRSW,
    S_DCLR, S_PDLL, S_UPDW, S_UPD2
  } st_t;

  st_t state, state_nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    state_nxt = state;
    case (state)
      S_IDLE:  if (sleep_req && sleep_type == 2'd0) state_nxt = S_ENTER;
      S_ENTER: state_nxt = S_WENT;
      S_WENT:  if (sr_entered) state_nxt = S_SR;
      S_SR:    if (!sleep_req) state_nxt = S_SYNC;
      S_SYNC:  state_nxt = mem_ddr2 ? S_DSET : S_PDLL;
      S_DSET:  state_nxt = S_MRS;
      S_MRS:   state_nxt = S_MRSW;
      S_MRSW:  if (mrs_done) state_nxt = S_DCLR;
      S_DCLR:  state_nxt = S_PDLL;
      S_PDLL:  if (cnt == PHY_LAST) state_nxt = S_UPDW;
      S_UPDW:  if (cnt == SLAVE_LAST) state_nxt = S_UPD2;
      S_UPD2:  state_nxt = S_IDLE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= (state_nxt != state) ? '0 : cnt + 1'b1;
    end
  end

  assign sleep_ack    = !(state inside {S_IDLE, S_ENTER, S_WENT});
  assign sr_enter     = (state == S_ENTER);
  assign phy_sync     = (state == S_SYNC);
  assign dram_dll_set = (state == S_DSET);
  assign mrs_cmd      = (state == S_MRS);
  assign dram_dll_clr = (state == S_DCLR);
  assign access_block = (state == S_PDLL);
  assign phy_dll_rst  = (state == S_PDLL) && (cnt == '0);
  assign slave_upd    = ((state == S_UPDW) && (cnt == '0)) || (state == S_UPD2);

  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter, phy_sync, dram_dll_set, mrs_cmd, dram_dll_clr, phy_dll_rst, slave_upd}));
  p_enter_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> !sr_enter);
  p_upd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slave_upd |=> !slave_upd);
  p_enter_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |-> ($past(sleep_type) == 2'd0) && $past(sleep_req));
  p_sync_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_sync |-> $past(sleep_ack) && !$past(sleep_req));
  p_lp_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_cmd || dram_dll_set || dram_dll_clr) |-> mem_ddr2);
  p_block_then_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(access_block) |-> slave_upd);
  p_ack_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> $past(slave_upd));

endmodule

// File: tb/sr_sequencer_bench.sv
module sr_sequencer_bench;
  localparam int PW = 16;
  localparam int SW = 8;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, mem_ddr2 = 0, sr_entered = 0, mrs_done = 0;
  logic [1:0] sleep_type = 2'd0;
  logic sleep_ack, sr_enter, phy_sync, dram_dll_set, mrs_cmd, dram_dll_clr;
  logic phy_dll_rst, slave_upd, access_block;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sr_sequencer #(.PHY_WAIT(PW), .SLAVE_WAIT(SW)) u_sr_sequencer (
    .clk, .rst_n, .sleep_req, .sleep_type, .mem_ddr2, .sr_entered, .mrs_done,
    .sleep_ack, .sr_enter, .phy_sync, .dram_dll_set, .mrs_cmd, .dram_dll_clr,
    .phy_dll_rst, .slave_upd, .access_block);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int strobes();
    return int'(sr_enter) + int'(phy_sync) + int'(dram_dll_set) + int'(mrs_cmd)
         + int'(dram_dll_clr) + int'(phy_dll_rst) + int'(slave_upd);
  endfunction

  task automatic do_entry(input int e, input bit drop);
    int enter_c = -1, ack_c = -1, n_enter = 0, sync_c = -1;
    @(negedge clk);
    sleep_type = 2'd0;
    sleep_req = 1;
    for (int c = 1; c < 60; c++) begin
      @(negedge clk);
      if (sr_enter) begin n_enter++; if (enter_c < 0) enter_c = c; end
      if (sleep_ack && ack_c < 0) ack_c = c;
      if (phy_sync && sync_c < 0) sync_c = c;
      if (c == 1 + e) sr_entered = 1;
      if (drop && c == 2) sleep_req = 0;
      if (!drop && ack_c > 0) break;
      if (drop && sync_c > 0) break;
    end
    sr_entered = 0;
    chk(enter_c == 1, "R3 enter strobe cycle", enter_c, 1);
    chk(n_enter == 1, "R11 single enter strobe", n_enter, 1);
    chk(ack_c == 2 + e, "R3 ack rise cycle", ack_c, 2 + e);
    if (drop) begin
      chk(sync_c == ack_c + 1, "R10 dropped request exits after ack", sync_c, ack_c + 1);
      for (int c = 0; c < 200 && sleep_ack; c++) @(negedge clk);
    end
  endtask

  task automatic do_exit(input bit ddr2, input int d, input bit rereq);
    int sync_c = -1, dset_c = -1, mrs_c = -1, dclr_c = -1, pdll_c = -1;
    int blk_first = -1, blk_n = 0, u1 = -1, u2 = -1, fall_c = -1, ent_c = -1;
    int ddr_n = 0, multi = 0, p;
    @(negedge clk);
    sleep_req = 0;
    for (int c = 1; c < 200; c++) begin
      @(negedge clk);
      mrs_done = 0;
      if (strobes() > 1) multi++;
      if (phy_sync && sync_c < 0) sync_c = c;
      if (dram_dll_set) begin ddr_n++; if (dset_c < 0) dset_c = c; end
      if (mrs_cmd) begin ddr_n++; if (mrs_c < 0) mrs_c = c; end
      if (dram_dll_clr) begin ddr_n++; if (dclr_c < 0) dclr_c = c; end
      if (phy_dll_rst && pdll_c < 0) pdll_c = c;
      if (access_block) begin blk_n++; if (blk_first < 0) blk_first = c; end
      if (slave_upd) begin if (u1 < 0) u1 = c; else if (u2 < 0) u2 = c; end
      if (!sleep_ack && fall_c < 0) fall_c = c;
      if (sr_enter && ent_c < 0) ent_c = c;
      if (mrs_c > 0 && c == mrs_c + d) mrs_done = 1;
      if (rereq && pdll_c > 0 && c == pdll_c + 2) sleep_req = 1;
      if (fall_c > 0 && c >= fall_c + 1) break;
    end
    p = ddr2 ? 5 + d : 2;
    chk(sync_c == 1, "R4 phy_sync first", sync_c, 1);
    if (ddr2) begin
      chk(dset_c == 2, "R5 dll set cycle", dset_c, 2);
      chk(mrs_c == 3, "R5 mrs cycle", mrs_c, 3);
      chk(dclr_c == 4 + d, "R5 dll clear after done", dclr_c, 4 + d);
    end else
      chk(ddr_n == 0, "R6 ddr2 strobes skipped", ddr_n, 0);
    chk(pdll_c == p, "R6 R7 phy dll reset cycle", pdll_c, p);
    chk(blk_first == p, "R7 block start", blk_first, p);
    chk(blk_n == PW, "R7 block length", blk_n, PW);
    chk(u1 == p + PW, "R8 first update", u1, p + PW);
    chk(u2 == p + PW + SW, "R8 second update", u2, p + PW + SW);
    chk(fall_c == p + PW + SW + 1, "R9 ack fall", fall_c, p + PW + SW + 1);
    chk(multi == 0, "R11 one strobe per cycle", multi, 0);
    if (rereq) begin
      chk(ent_c == fall_c + 1, "R10 held request re-enters", ent_c, fall_c + 1);
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (c == 1) sr_entered = 1;
      end
      sr_entered = 0;
    end else
      chk(ent_c < 0, "R10 no spurious entry", ent_c, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sleep_ack && !access_block && strobes() == 0, "R1 reset outputs",
        int'(sleep_ack) + int'(access_block) + strobes(), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!sleep_ack && strobes() == 0, "R1 first cycle after reset", strobes(), 0);

    for (int t = 1; t < 4; t++) begin
      int seen = 0;
      sleep_type = 2'(t);
      sleep_req = 1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (sr_enter || sleep_ack) seen++;
      end
      chk(seen == 0, "R2 non-self-refresh type ignored", seen, 0);
      sleep_req = 0;
      @(negedge clk);
    end

    for (int dd = 0; dd < 2; dd++) begin
      for (int d = 1; d < (dd ? 4 : 2); d++) begin
        for (int e = 1; e < 4; e++) begin
          mem_ddr2 = dd[0];
          do_entry(e, 0);
          do_exit(dd[0], d, 0);
        end
      end
    end

    mem_ddr2 = 1;
    do_entry(2, 0);
    do_exit(1, 2, 1);
    do_exit(1, 1, 0);

    mem_ddr2 = 0;
    do_entry(1, 1);
    do_entry(3, 0);
    do_exit(0, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule